// File: doc/BRIEF.md
# UART Processor Register Front End

This block is the processor-facing register layer of a UART. It sits between a simple 8-bit bus and the serial cores. The bus side consists of a select, a read/write strobe, a 2-bit address, write data and read data. The transmit core, receive core and baud divider live outside the block.

The block holds the byte to be transmitted and the control register. It keeps four handshake and error flags. Single-cycle set pulses from the serial cores raise these flags, and processor accesses clear them as a side effect. It returns the receiver's byte, the status flags or the control register on reads.

Toward the cores it drives a load strobe, the transmit byte and a 3-bit baud code. It also produces one interrupt request, gated per source by enable bits in the control register. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, a status read (address 01) returns 0x80 (transmit-empty set, all other flags clear), a control read returns 0x00, `tx_byte` is 0x00 and `irq` is 0.
- R2: A write (`sel`=1, `wr`=1) to address 00 pulses `tx_load` in that cycle, makes `tx_byte` equal to the written byte from the next cycle, and clears the transmit-empty flag (status bit 7).
- R3: A `tx_taken` pulse sets the transmit-empty flag in the following cycle.
- R4: An `rx_done` pulse sets the receive-full flag (status bit 6). A read (`sel`=1, `wr`=0) of address 00 returns `rx_byte` combinationally and clears receive-full, overrun and framing flags at the end of that cycle.
- R5: An `rx_overrun` pulse sets status bit 1 and an `rx_frame_err` pulse sets status bit 0. Status bits 5:2 always read 0.
- R6: When a set pulse and the access that would clear the same flag fall in one cycle, the flag ends up set.
- R7: A write to address 10 stores bit 7 (transmit interrupt enable), bit 6 (receive interrupt enable) and bits 2:0 (baud code, driven on `baud_sel`). Reads of address 10 or 11 return the stored value with bits 5:3 as 0.
- R8: `irq` equals (control bit 7 AND transmit-empty) OR (control bit 6 AND receive-full) in every cycle.
- R9: Nothing changes when `sel` is 0. Writes to addresses 01 and 11 change nothing. `rdata` is 0x00 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Block select |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data from processor |
| rdata | output | 8 | Read data to processor |
| rx_byte | input | 8 | Byte held by the receive core |
| rx_done | input | 1 | Receive core: frame complete pulse |
| rx_overrun | input | 1 | Receive core: overrun pulse |
| rx_frame_err | input | 1 | Receive core: missing stop bit pulse |
| tx_taken | input | 1 | Transmit core: byte moved to shifter pulse |
| tx_load | output | 1 | Strobe: new transmit byte written |
| tx_byte | output | 8 | Transmit byte to the core |
| baud_sel | output | 3 | Baud code to the divider |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can fall in the same cycle on this block. A core's set pulse can coincide with the processor access that clears the same flag: `tx_taken` with a data write, or `rx_done` and the error pulses with a data read. The bench provokes both pairings in directed cycles and also lets them collide during a long random phase. A per-cycle behavioural model, in which set has priority, judges every cycle's status, read data and interrupt.

// File: rtl/uhr_pkg.sv
package uhr_pkg;
  typedef enum logic [1:0] {
    ADR_DATA  = 2'b00,
    ADR_STAT  = 2'b01,
    ADR_CTRL  = 2'b10,
    ADR_CTRL2 = 2'b11
  } reg_addr_e;

  localparam int NFLAG   = 4;
  localparam int FL_TXE  = 3;
  localparam int FL_RXF  = 2;
  localparam int FL_OVR  = 1;
  localparam int FL_FE   = 0;
  localparam logic [NFLAG-1:0] FLAG_RST = 4'b1000;

  typedef struct packed {
    logic wr_data;
    logic rd_data;
    logic wr_ctrl;
    logic rd_stat;
    logic rd_ctrl;
  } access_t;
endpackage

// File: rtl/uhr_rst_sync.sv
module uhr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/uhr_decode.sv
module uhr_decode
  import uhr_pkg::*;
(
  input  logic       sel,
  input  logic       wr,
  input  logic [1:0] addr,
  output access_t    acc
);
  reg_addr_e a;
  logic      do_wr;
  logic      do_rd;

  always_comb begin
    a     = reg_addr_e'(addr);
    do_wr = sel & wr;
    do_rd = sel & ~wr;
    acc   = '0;
    acc.wr_data = do_wr && (a == ADR_DATA);
    acc.wr_ctrl = do_wr && (a == ADR_CTRL);
    acc.rd_data = do_rd && (a == ADR_DATA);
    acc.rd_stat = do_rd && (a == ADR_STAT);
    acc.rd_ctrl = do_rd && ((a == ADR_CTRL) || (a == ADR_CTRL2));
  end
endmodule

// File: rtl/uhr_flag.sv
module uhr_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RST_VAL;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/uhr_ctrl.sv
module uhr_ctrl #(
  parameter int DW     = 8,
  parameter int BAUD_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o
);
  localparam logic [DW-1:0] KEEP_MASK =
    DW'((1 << (DW-1)) | (1 << (DW-2)) | ((1 << BAUD_W) - 1));

  logic [DW-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_o;
    if (load_i) ctrl_d = wdata_i & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_o <= '0;
    else        ctrl_o <= ctrl_d;
  end
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uhr_pkg::*;
#(
  parameter int DW     = 8,
  parameter int BAUD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     rx_byte,
  input  logic              rx_done,
  input  logic              rx_overrun,
  input  logic              rx_frame_err,
  input  logic              tx_taken,
  output logic              tx_load,
  output logic [DW-1:0]     tx_byte,
  output logic [BAUD_W-1:0] baud_sel,
  output logic              irq
);
  localparam int TXIE = DW - 1;
  localparam int RXIE = DW - 2;

  logic             rst_sync_n;
  access_t          acc;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;
  logic [NFLAG-1:0] flag_q;
  logic [DW-1:0]    ctrl_q;
  logic [DW-1:0]    tdr_q;
  logic [DW-1:0]    tdr_d;
  logic [DW-1:0]    status;

  uhr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  uhr_decode u_dec (.sel(sel), .wr(wr), .addr(addr), .acc(acc));

  always_comb begin
    flag_set         = '0;
    flag_clr         = '0;
    flag_set[FL_TXE] = tx_taken;
    flag_set[FL_RXF] = rx_done;
    flag_set[FL_OVR] = rx_overrun;
    flag_set[FL_FE]  = rx_frame_err;
    flag_clr[FL_TXE] = acc.wr_data;
    flag_clr[FL_RXF] = acc.rd_data;
    flag_clr[FL_OVR] = acc.rd_data;
    flag_clr[FL_FE]  = acc.rd_data;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    uhr_flag #(.RST_VAL(FLAG_RST[i])) u_flag (
      .clk(clk), .rst_n(rst_sync_n),
      .set_i(flag_set[i]), .clr_i(flag_clr[i]), .q_o(flag_q[i])
    );
  end

  uhr_ctrl #(.DW(DW), .BAUD_W(BAUD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .load_i(acc.wr_ctrl), .wdata_i(wdata), .ctrl_o(ctrl_q)
  );

  always_comb begin
    tdr_d = tdr_q;
    if (acc.wr_data) tdr_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) tdr_q <= '0;
    else             tdr_q <= tdr_d;
  end

  always_comb begin
    status         = '0;
    status[DW-1]   = flag_q[FL_TXE];
    status[DW-2]   = flag_q[FL_RXF];
    status[1]      = flag_q[FL_OVR];
    status[0]      = flag_q[FL_FE];
  end

  always_comb begin
    rdata = '0;
    if (acc.rd_data) rdata = rx_byte;
    if (acc.rd_stat) rdata = status;
    if (acc.rd_ctrl) rdata = ctrl_q;
  end

  assign tx_load  = acc.wr_data;
  assign tx_byte  = tdr_q;
  assign baud_sel = ctrl_q[BAUD_W-1:0];
  assign irq      = (ctrl_q[TXIE] & flag_q[FL_TXE]) | (ctrl_q[RXIE] & flag_q[FL_RXF]);
endmodule

// File: rtl/uhr_checker.sv
module uhr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       wr,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       rx_done,
  input logic       rx_overrun,
  input logic       rx_frame_err,
  input logic       tx_taken,
  input logic [3:0] flags,
  input logic [7:0] ctrl,
  input logic [2:0] baud_sel,
  input logic       irq
);
  logic data_wr, data_rd, ctrl_wr;
  assign data_wr = sel && wr && (addr == 2'b00);
  assign data_rd = sel && !wr && (addr == 2'b00);
  assign ctrl_wr = sel && wr && (addr == 2'b10);

  assert_txe_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !tx_taken) |=> !flags[3]);
  assert_txe_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken |=> flags[3]);
  assert_rxf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> flags[2]);
  assert_rd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rx_done && !rx_overrun && !rx_frame_err) |=> (flags[2:0] == 3'b000));
  assert_ovr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> flags[1]);
  assert_fe_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |=> flags[0]);
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && rx_done) |=> flags[2]);
  assert_baud_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (baud_sel == $past(wdata[2:0])));
  assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((ctrl[7] && flags[3]) || (ctrl[6] && flags[2])));
  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl));
endmodule

bind uart_host_regs uhr_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sel(sel), .wr(wr), .addr(addr),
  .wdata(wdata), .rx_done(rx_done), .rx_overrun(rx_overrun),
  .rx_frame_err(rx_frame_err), .tx_taken(tx_taken), .flags(flag_q),
  .ctrl(ctrl_q), .baud_sel(baud_sel), .irq(irq)
);

// File: tb/uart_host_regs_bench.sv
module uart_host_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel, wr, rx_done, rx_overrun, rx_frame_err, tx_taken;
  logic [1:0] addr;
  logic [7:0] wdata, rx_byte;
  logic [7:0] rdata, tx_byte;
  logic [2:0] baud_sel;
  logic       tx_load, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  bit       m_txe, m_rxf, m_ovr, m_fe;
  bit [7:0] m_ctrl, m_tdr;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_host_regs u_uart_host_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte), .rx_done(rx_done),
    .rx_overrun(rx_overrun), .rx_frame_err(rx_frame_err), .tx_taken(tx_taken),
    .tx_load(tx_load), .tx_byte(tx_byte), .baud_sel(baud_sel), .irq(irq)
  );

  task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%02h expected=%02h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] m_status();
    return {m_txe, m_rxf, 4'b0000, m_ovr, m_fe};
  endfunction

  // one bus cycle: drive at negedge, compare mid-low phase, update model at posedge
  task automatic cyc(string tag, bit s, bit w, bit [1:0] a, bit [7:0] d,
                     bit [7:0] rb, bit rd, bit ro, bit rf, bit tt);
    bit [7:0] exp_rd;
    @(negedge clk);
    sel = s; wr = w; addr = a; wdata = d; rx_byte = rb;
    rx_done = rd; rx_overrun = ro; rx_frame_err = rf; tx_taken = tt;
    #(CLK_PERIOD/4);
    exp_rd = 8'h00;
    if (s && !w) begin
      if (a == 2'b00)      exp_rd = rb;
      else if (a == 2'b01) exp_rd = m_status();
      else                 exp_rd = m_ctrl;
    end
    cmp(tag, "rdata", rdata, exp_rd);
    cmp(tag, "tx_load", {7'b0, tx_load}, {7'b0, (s && w && a == 2'b00)});
    cmp(tag, "tx_byte", tx_byte, m_tdr);
    cmp(tag, "baud_sel", {5'b0, baud_sel}, {5'b0, m_ctrl[2:0]});
    cmp(tag, "irq", {7'b0, irq}, {7'b0, ((m_ctrl[7] && m_txe) || (m_ctrl[6] && m_rxf))});
    @(posedge clk);
    begin
      bit dwr = s && w && a == 2'b00;
      bit drd = s && !w && a == 2'b00;
      if (tt) m_txe = 1; else if (dwr) m_txe = 0;
      if (rd) m_rxf = 1; else if (drd) m_rxf = 0;
      if (ro) m_ovr = 1; else if (drd) m_ovr = 0;
      if (rf) m_fe  = 1; else if (drd) m_fe  = 0;
      if (dwr) m_tdr = d;
      if (s && w && a == 2'b10) m_ctrl = {d[7:6], 3'b000, d[2:0]};
    end
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 2'b00, 8'h00, 8'h00, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    sel = 0; wr = 0; addr = 0; wdata = 0; rx_byte = 0;
    rx_done = 0; rx_overrun = 0; rx_frame_err = 0; tx_taken = 0;
    m_txe = 1; m_rxf = 0; m_ovr = 0; m_fe = 0; m_ctrl = 0; m_tdr = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 reset values
    cyc("R1", 1, 0, 2'b01, 8'h00, 8'h00, 0, 0, 0, 0);
    cyc("R1", 1, 0, 2'b11, 8'h00, 8'h00, 0, 0, 0, 0);
    idle("R1");

    // R7 control write with transmit enable only, R8 irq follows
    cyc("R7", 1, 1, 2'b10, 8'h80, 8'h00, 0, 0, 0, 0);
    cyc("R8", 1, 0, 2'b11, 8'h00, 8'h00, 0, 0, 0, 0);

    // R2 data write clears empty, irq drops
    cyc("R2", 1, 1, 2'b00, 8'h69, 8'h00, 0, 0, 0, 0);
    cyc("R2", 1, 0, 2'b01, 8'h00, 8'h00, 0, 0, 0, 0);
    // R3 transmitter takes byte
    cyc("R3", 0, 0, 2'b00, 8'h00, 8'h00, 0, 0, 0, 1);
    cyc("R3", 1, 0, 2'b01, 8'h00, 8'h00, 0, 0, 0, 0);

    // R7 full write masks bits 5:3, readable at 10 and 11
    cyc("R7", 1, 1, 2'b10, 8'hFD, 8'h00, 0, 0, 0, 0);
    cyc("R7", 1, 0, 2'b10, 8'h00, 8'h00, 0, 0, 0, 0);
    cyc("R7", 1, 1, 2'b10, 8'h45, 8'h00, 0, 0, 0, 0);
    cyc("R7", 1, 0, 2'b11, 8'h00, 8'h00, 0, 0, 0, 0);

    // R4 receive full, R8 receive irq
    cyc("R4", 0, 0, 2'b00, 8'h00, 8'hA5, 1, 0, 0, 0);
    cyc("R8", 1, 0, 2'b01, 8'h00, 8'hA5, 0, 0, 0, 0);
    // R5 error pulses
    cyc("R5", 0, 0, 2'b00, 8'h00, 8'hA5, 0, 1, 0, 0);
    cyc("R5", 0, 0, 2'b00, 8'h00, 8'hA5, 0, 0, 1, 0);
    cyc("R5", 1, 0, 2'b01, 8'h00, 8'hA5, 0, 0, 0, 0);
    // R9 deselected access and writes to status/11 change nothing
    cyc("R9", 0, 0, 2'b00, 8'h00, 8'hA5, 0, 0, 0, 0);
    cyc("R9", 0, 1, 2'b00, 8'h33, 8'hA5, 0, 0, 0, 0);
    cyc("R9", 0, 1, 2'b10, 8'h07, 8'hA5, 0, 0, 0, 0);
    cyc("R9", 1, 1, 2'b01, 8'h00, 8'hA5, 0, 0, 0, 0);
    cyc("R9", 1, 1, 2'b11, 8'h00, 8'hA5, 0, 0, 0, 0);
    cyc("R9", 1, 0, 2'b01, 8'h00, 8'hA5, 0, 0, 0, 0);
    cyc("R9", 1, 0, 2'b11, 8'h00, 8'hA5, 0, 0, 0, 0);
    // R4 data read returns byte and clears
    cyc("R4", 1, 0, 2'b00, 8'h00, 8'hA5, 0, 0, 0, 0);
    cyc("R4", 1, 0, 2'b01, 8'h00, 8'h00, 0, 0, 0, 0);

    // R6 collisions
    cyc("R6", 0, 0, 2'b00, 8'h00, 8'h11, 1, 0, 0, 0);
    cyc("R6", 1, 0, 2'b00, 8'h00, 8'h22, 1, 1, 1, 0);
    cyc("R6", 1, 0, 2'b01, 8'h00, 8'h00, 0, 0, 0, 0);
    cyc("R6", 1, 1, 2'b00, 8'h3C, 8'h00, 0, 0, 0, 1);
    cyc("R6", 1, 0, 2'b01, 8'h00, 8'h00, 0, 0, 0, 0);
    cyc("R2", 1, 1, 2'b00, 8'hAA, 8'h00, 0, 0, 0, 0);
    cyc("R2", 1, 0, 2'b01, 8'h00, 8'h00, 0, 0, 0, 0);

    // R8 random traffic
    for (int i = 0; i < 2000; i++) begin
      bit [31:0] r = $urandom;
      bit [31:0] q = $urandom;
      cyc("R8", r[0], r[1], r[3:2], q[7:0], q[15:8],
          (r[7:4] == 0), (r[11:8] == 0), (r[15:12] == 0), (r[19:16] < 3));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule